// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one 8-pin general-purpose I/O port that sits behind a small register bus. A 16-bit mode register gives every pin a 2-bit field. That field chooses one of four states: the pin handed to an alternate peripheral, a plain output, an input with the pull-up on, or an input with the pull-up off. For every pin the block drives an output value, an output enable, a pull-up enable and an alternate-select line toward the pad ring.

An 8-bit output latch holds the level that output-mode pins drive. The latch accepts writes in every mode, but its contents reach a pin only while that pin is in output mode. A read of the latch's address never returns the latch. It returns the live pin levels, taken through a two-flop synchronizer.

The register bus has a single cycle. A write takes effect at the clock edge where it is presented. Read data is registered, so the word for the address presented at one edge is valid after that edge. The bus carries no flow control: every access completes, so there is no back-pressure to manage.

Top module: `gpio_port8`

## Requirements
- R1: The mode register is 16 bits. Pin n's mode field is bits 2n+1:2n, so pin 7 is bits 15:14. Every bit reads back as written. Byte enable bit 0 gates bits 7:0 and byte enable bit 1 gates bits 15:8.
- R2: After reset the mode register reads 16'hFFFF and the output latch holds 8'h00. With these values every pin is an input with pin_oe, pin_pu and pin_alt all 0.
- R3: Mode 2'b00 (alternate): pin_alt is 1, pin_oe follows alt_oe, pin_out follows alt_out, and pin_pu is 0.
- R4: Mode 2'b01 (output): pin_oe is 1, pin_out equals the latch bit, and pin_pu and pin_alt are 0.
- R5: Mode 2'b10 (input, pull-up on): pin_pu is 1, and pin_oe, pin_out and pin_alt are 0.
- R6: Mode 2'b11 (input, pull-up off): pin_pu, pin_oe, pin_out and pin_alt are all 0.
- R7: A latch write leaves the outputs of pins that are not in output mode unchanged. The stored value is driven later, once the pin is switched to output mode.
- R8: A read at the latch address (byte offset 2) returns the synchronized pin levels in bits 7:0 and zero in bits 15:8, in every mode. A pin change set up before rising edge k shows on bus_rdata after edge k+2, with the address held.
- R9: bus_rdata is registered and shows the word for the address presented at the previous rising edge. The mode register is at byte offset 0. Every other address reads 16'h0000.
- R10: The latch is written only when byte enable bit 0 is set. A latch write with only bit 1 set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| alt_out | input | 8 | Alternate peripheral output value per pin |
| alt_oe | input | 8 | Alternate peripheral output enable per pin |
| pin_out | output | 8 | Pad output value |
| pin_oe | output | 8 | Pad output enable |
| pin_pu | output | 8 | Pad pull-up enable |
| pin_alt | output | 8 | Pad alternate-function select |

## Verification
The decode assertions assume that a mode-register write which enables both bytes gives the complete new mode word. Under that assumption the alternate-select and output-enable patterns in the next cycle follow from the written word alone. The stability check on latch writes assumes that no mode write lands in the same cycle, and the bench never presents one. The bench drives each bus access for exactly one cycle, starting at a falling edge. It changes pad levels only at falling edges, with the address held for latency checks, so every asynchronous input stays within the two-flop synchronizer's reach. A pad model in the bench loops driven values back to pin_in, which lets the latch's contents be seen through the pin-level read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_ALT   = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_IN_PU = 2'b10,
    MODE_IN    = 2'b11
  } pin_mode_e;

  localparam int unsigned MODE_W = 2;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned NPINS    = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned DATA_OFS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [2*NPINS/8-1:0]  bus_be,
  input  logic [2*NPINS-1:0]    bus_wdata,
  output logic [2*NPINS-1:0]    bus_rdata,
  input  logic [NPINS-1:0]      pins_sync,
  output logic [2*NPINS-1:0]    mode_q,
  output logic [NPINS-1:0]      latch_q
);
  localparam int unsigned BUS_W = 2 * NPINS;

  logic hit_ctrl, hit_data;
  logic [BUS_W-1:0] rd_next;

  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
  assign hit_data = (bus_addr == ADDR_W'(DATA_OFS));

  genvar i;
  generate
    for (i = 0; i < BUS_W; i++) begin : g_mode_bit
      always_ff @(posedge clk) begin
        if (!rst_n)
          mode_q[i] <= 1'b1;
        else if (bus_we && hit_ctrl && bus_be[i / gpio_pkg::BYTE_W])
          mode_q[i] <= bus_wdata[i];
      end
    end
    for (i = 0; i < NPINS; i++) begin : g_latch_bit
      always_ff @(posedge clk) begin
        if (!rst_n)
          latch_q[i] <= 1'b0;
        else if (bus_we && hit_data && bus_be[i / gpio_pkg::BYTE_W])
          latch_q[i] <= bus_wdata[i];
      end
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (hit_ctrl)      rd_next = mode_q;
    else if (hit_data) rd_next = {{(BUS_W-NPINS){1'b0}}, pins_sync};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int unsigned NPINS = 8
) (
  input  logic [2*NPINS-1:0] mode_q,
  input  logic [NPINS-1:0]   latch_q,
  input  logic [NPINS-1:0]   alt_out,
  input  logic [NPINS-1:0]   alt_oe,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_pu,
  output logic [NPINS-1:0]   pin_alt
);
  import gpio_pkg::*;

  genvar n;
  generate
    for (n = 0; n < NPINS; n++) begin : g_pin
      pin_mode_e mode;
      logic o_val, o_en, pu_en, alt_sel;

      assign mode = pin_mode_e'(mode_q[MODE_W*n +: MODE_W]);

      always_comb begin
        o_val   = 1'b0;
        o_en    = 1'b0;
        pu_en   = 1'b0;
        alt_sel = 1'b0;
        unique case (mode)
          MODE_ALT: begin
            alt_sel = 1'b1;
            o_val   = alt_out[n];
            o_en    = alt_oe[n];
          end
          MODE_OUT: begin
            o_val = latch_q[n];
            o_en  = 1'b1;
          end
          MODE_IN_PU: pu_en = 1'b1;
          default: ;
        endcase
      end

      assign pin_out[n] = o_val;
      assign pin_oe[n]  = o_en;
      assign pin_pu[n]  = pu_en;
      assign pin_alt[n] = alt_sel;
    end
  endgenerate
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CTRL_OFS    = 0,
  parameter int unsigned DATA_OFS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [2*NPINS/8-1:0] bus_be,
  input  logic [2*NPINS-1:0]   bus_wdata,
  output logic [2*NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  input  logic [NPINS-1:0]     alt_out,
  input  logic [NPINS-1:0]     alt_oe,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic [NPINS-1:0]     pin_pu,
  output logic [NPINS-1:0]     pin_alt
);
  localparam int unsigned BUS_W = 2 * NPINS;

  logic [NPINS-1:0] pins_sync;
  logic [BUS_W-1:0] mode_q;
  logic [NPINS-1:0] latch_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (pins_sync)
  );

  gpio_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_sync (pins_sync),
    .mode_q    (mode_q),
    .latch_q   (latch_q)
  );

  gpio_pinmux #(.NPINS(NPINS)) u_mux (
    .mode_q  (mode_q),
    .latch_q (latch_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_pu  (pin_pu),
    .pin_alt (pin_alt)
  );
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int unsigned NPINS    = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned DATA_OFS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [2*NPINS/8-1:0] bus_be,
  input logic [2*NPINS-1:0]   bus_wdata,
  input logic [2*NPINS-1:0]   bus_rdata,
  input logic [NPINS-1:0]     pin_oe,
  input logic [NPINS-1:0]     pin_pu,
  input logic [NPINS-1:0]     pin_alt
);
  localparam logic [2*NPINS/8-1:0] BE_ALL = '1;

  function automatic logic [NPINS-1:0] mask_of(input logic [2*NPINS-1:0] w,
                                               input logic [1:0] code);
    logic [NPINS-1:0] m;
    for (int k = 0; k < NPINS; k++) m[k] = (w[2*k +: 2] == code);
    return m;
  endfunction

  logic wr_ctrl_full, wr_data, rd_data, rd_unmapped;
  assign wr_ctrl_full = bus_we && bus_addr == ADDR_W'(CTRL_OFS) && bus_be == BE_ALL;
  assign wr_data      = bus_we && bus_addr == ADDR_W'(DATA_OFS);
  assign rd_data      = bus_addr == ADDR_W'(DATA_OFS);
  assign rd_unmapped  = bus_addr != ADDR_W'(CTRL_OFS) && bus_addr != ADDR_W'(DATA_OFS);

  // R3: alternate select follows the 2'b00 fields of a full mode write
  p_alt_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_full |=> pin_alt == mask_of($past(bus_wdata), 2'b00));

  // R4: non-alternate output enables follow the 2'b01 fields
  p_oe_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_full |=> (pin_oe & ~pin_alt) == mask_of($past(bus_wdata), 2'b01));

  // R5: pull-up never coexists with a driven or alternate pin
  p_pu_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & (pin_oe | pin_alt)) == '0);

  // R7: a latch write leaves the non-alternate enables untouched
  p_latch_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> $stable(pin_oe & ~pin_alt) && $stable(pin_pu));

  // R8: pin-level reads carry zero in the upper byte
  p_rd_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |=> bus_rdata[2*NPINS-1:NPINS] == '0);

  // R9: unmapped addresses read zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> bus_rdata == '0);
endmodule

bind gpio_port8 gpio_port8_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
) u_chk (.*);

// File: tb/gpio_port8_test.sv
`timescale 1ns/1ps
module gpio_port8_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  alt_out = '0;
  logic [7:0]  alt_oe = '0;
  logic [7:0]  pin_out, pin_oe, pin_pu, pin_alt;
  logic [7:0]  ext = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // pad model: driven value loops back, else pull-up or external level
  always_comb
    for (int k = 0; k < 8; k++)
      pin_in[k] = pin_oe[k] ? pin_out[k] : (pin_pu[k] ? 1'b1 : ext[k]);

  gpio_port8 uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_alt(pin_alt)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'd0, d);
    chk("R2 mode reset", d, 16'hFFFF);
    chk("R2 oe", {8'h0, pin_oe}, 16'h0);
    chk("R2 pu", {8'h0, pin_pu}, 16'h0);
    chk("R2 alt", {8'h0, pin_alt}, 16'h0);
    ext = 8'hA5; settle();
    rd(4'd2, d);
    chk("R8 input read", d, 16'h00A5);
    wr(4'd0, 2'b11, 16'h5555);
    chk("R2 latch reset drives low", {8'h0, pin_out}, 16'h0);
    chk("R4 all output oe", {8'h0, pin_oe}, 16'h00FF);
    wr(4'd0, 2'b11, 16'hFFFF);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    wr(4'd2, 2'b01, 16'h00FF);
    chk("R7 latch write in input mode oe", {8'h0, pin_oe}, 16'h0);
    chk("R7 latch write in input mode out", {8'h0, pin_out}, 16'h0);
    alt_out = 8'h11; alt_oe = 8'h10;
    // modes per pin 0..7: 00,01,10,11,00,01,10,11
    wr(4'd0, 2'b11, 16'hE4E4);
    rd(4'd0, d);
    chk("R1 mode readback", d, 16'hE4E4);
    chk("R3 alt select", {8'h0, pin_alt}, 16'h0011);
    chk("R3/R4 oe", {8'h0, pin_oe}, 16'h0032);
    chk("R3/R4 out", {8'h0, pin_out}, 16'h0033);
    chk("R5/R6 pull-up", {8'h0, pin_pu}, 16'h0044);
    alt_out = 8'h01; alt_oe = 8'h11; #1;
    chk("R3 alt follows", {pin_oe, pin_out}, {8'h33, 8'h23});
  endtask

  task automatic t_byte_en();
    logic [15:0] d;
    wr(4'd0, 2'b01, 16'h5555);
    rd(4'd0, d);
    chk("R1 low byte only", d, 16'hE455);
    wr(4'd0, 2'b10, 16'hAAAA);
    rd(4'd0, d);
    chk("R1 high byte only", d, 16'hAA55);
    wr(4'd2, 2'b10, 16'h0000);
    wr(4'd0, 2'b11, 16'h5555);
    chk("R10 upper enable ignored", {8'h0, pin_out}, 16'h00FF);
    chk("R7 stored value driven", {8'h0, pin_oe}, 16'h00FF);
    wr(4'd2, 2'b01, 16'hFF3C);
    chk("R4 output follows latch", {8'h0, pin_out}, 16'h003C);
    settle();
    rd(4'd2, d);
    chk("R8 loopback read", d, 16'h003C);
  endtask

  task automatic t_latency();
    logic [15:0] d;
    wr(4'd0, 2'b11, 16'hFFFF);
    ext = 8'h00; settle();
    @(negedge clk); bus_addr = 4'd2;
    repeat (2) @(negedge clk);
    chk("R8 settled", bus_rdata, 16'h0000);
    ext = 8'h5A;
    @(negedge clk);
    chk("R8 after 1 edge", bus_rdata, 16'h0000);
    @(negedge clk);
    chk("R8 after 2 edges", bus_rdata, 16'h0000);
    @(negedge clk);
    chk("R8 after 3 edges", bus_rdata, 16'h005A);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    rd(4'd4, d);
    chk("R9 unmapped", d, 16'h0000);
    rd(4'd0, d);
    chk("R9 mode address", d, 16'hFFFF);
    @(negedge clk); bus_addr = 4'd6;
    chk("R9 registered hold", bus_rdata, 16'hFFFF);
    @(negedge clk);
    chk("R9 next cycle", bus_rdata, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_byte_en();
    t_latency();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule